// File: doc/BRIEF.md
# Clock Control Register Block

This block holds the configuration words of a small microcontroller's power, reset and clock controller. It has four 32-bit registers: an internal ring-oscillator setup word, an external crystal-oscillator setup word, a PLL setup word and a PLL output-divider word. Firmware reaches them over a simple word-wide register bus. The bus carries an address, byte enables, a write strobe, a read strobe, write data and read data.

The oscillators and the PLL are not modelled as analog parts. The ready bits always read as one, and so does the lock bit. Firmware loops that wait on them therefore finish on the first poll. The block decodes the address and keeps the register contents. It also raises a one-cycle error pulse for any access that is not a full word to a mapped offset.

Top module: `clkctl_regs`

## Requirements
- R1: After reset, the four registers hold these values. The ring-oscillator word (offset 0x0) is 0xC000_0000: enable bit 30 and ready bit 31 are set. The crystal-oscillator word (offset 0x4) is 0xC000_0000. The PLL word (offset 0x8) is 0x8006_0000: reference-select bit 17, bypass bit 18 and lock bit 31 are set. The divider word (offset 0xC) is 0x0000_0100, with divide-by-one at bit 8. After reset, `bus_rdata` is zero and `bus_err` is low.
- R2: A write to the ring-oscillator word stores the data with bit 31 forced to one.
- R3: A write to the crystal-oscillator word stores the data with bit 31 forced to one.
- R4: A write to the PLL word stores the data with lock bit 31 forced to one.
- R5: A write to the divider word stores the data exactly, with no forced bits.
- R6: Read data appears on `bus_rdata` on the clock after the read strobe is sampled. In cycles without a read, `bus_rdata` keeps its last value.
- R7: A read and a write issued in the same cycle return the value the register held before the write. The write still takes effect.
- R8: A read to any offset whose bits [11:4] are not zero returns zero and raises `bus_err` for one cycle.
- R9: A write to an offset whose bits [11:4] are not zero changes no register and raises `bus_err` for one cycle.
- R10: An access whose `bus_be` is not 4'b1111 is rejected. A rejected write changes nothing, a rejected read returns zero, and `bus_err` pulses.
- R11: Address bits [1:0] play no part in decoding, so offset 0x5 reaches the crystal-oscillator word.
- R12: `bus_err` is high only in the cycle after a rejected access is sampled. Cycles with no strobe never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for a rejected access |

## Verification
The assertions check these properties on every cycle:
- Read data is stable between reads.
- A rejected read returns zero.
- Every status bit reads as one on the three setup words.
- The error pulse appears only after a rejected strobe and never after an idle cycle.

Some behaviours cannot be seen cycle by cycle and need the bench's scenarios: the stored data values, the reset contents, the old value returned by a read in the same cycle as a write, the fact that an unmapped or narrow write leaves every register untouched, and the ignored low address bits. A reference model predicts each of these.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DW       = 32;
  localparam int NREG     = 4;
  localparam int IDXW     = $clog2(NREG);
  localparam int BEW      = DW / 8;
  localparam int LSBW     = $clog2(BEW);

  localparam int OSC_EN_BIT   = 30;
  localparam int OSC_RDY_BIT  = 31;
  localparam int PLL_REF_BIT  = 17;
  localparam int PLL_BYP_BIT  = 18;
  localparam int PLL_LOCK_BIT = 31;
  localparam int DIV_ONE_BIT  = 8;

  typedef enum logic [IDXW-1:0] {
    SLOT_ROSC = 2'd0,
    SLOT_XOSC = 2'd1,
    SLOT_PLL  = 2'd2,
    SLOT_ODIV = 2'd3
  } slot_e;

  function automatic logic [DW-1:0] slot_reset(input int slot);
    logic [DW-1:0] v;
    v = '0;
    case (slot)
      SLOT_ROSC, SLOT_XOSC: begin
        v[OSC_EN_BIT]  = 1'b1;
        v[OSC_RDY_BIT] = 1'b1;
      end
      SLOT_PLL: begin
        v[PLL_REF_BIT]  = 1'b1;
        v[PLL_BYP_BIT]  = 1'b1;
        v[PLL_LOCK_BIT] = 1'b1;
      end
      default: v[DIV_ONE_BIT] = 1'b1;
    endcase
    return v;
  endfunction

  function automatic logic [DW-1:0] slot_sticky(input int slot);
    logic [DW-1:0] v;
    v = '0;
    case (slot)
      SLOT_ROSC, SLOT_XOSC: v[OSC_RDY_BIT]  = 1'b1;
      SLOT_PLL:             v[PLL_LOCK_BIT] = 1'b1;
      default:              v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
  import clkctl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]   addr,
  input  logic [BEW-1:0]  be,
  input  logic            rd,
  input  logic            wr,
  output logic [IDXW-1:0] slot,
  output logic            rd_ok,
  output logic            wr_ok,
  output logic            reject
);
  localparam int HI_LSB = IDXW + LSBW;

  logic full_word;
  logic mapped;
  logic legal;
  logic unused_low;

  assign unused_low = ^addr[LSBW-1:0];
  assign full_word  = &be;
  assign mapped     = (addr[AW-1:HI_LSB] == '0);
  assign legal      = full_word && mapped;
  assign slot       = addr[HI_LSB-1:LSBW];
  assign rd_ok      = rd && legal;
  assign wr_ok      = wr && legal;
  assign reject     = (rd || wr) && !legal;
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ok,
  input  logic [IDXW-1:0]          slot,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DW-1:0] RST_V = slot_reset(g);
    localparam logic [DW-1:0] STK_V = slot_sticky(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= RST_V;
      end else if (wr_ok && (slot == IDXW'(g))) begin
        regs[g] <= wdata | STK_V;
      end
    end
  end
endmodule

// File: rtl/clkctl_readback.sv
module clkctl_readback
  import clkctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd,
  input  logic                     rd_ok,
  input  logic                     reject,
  input  logic [IDXW-1:0]          slot,
  input  logic [NREG-1:0][DW-1:0]  regs,
  output logic [DW-1:0]            rdata,
  output logic                     err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= reject;
      if (rd) begin
        rdata <= rd_ok ? regs[slot] : '0;
      end
    end
  end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err
);
  logic [IDXW-1:0]         slot;
  logic                    rd_ok;
  logic                    wr_ok;
  logic                    reject;
  logic [NREG-1:0][DW-1:0] regs;

  clkctl_decode #(.AW(AW)) u_dec (
    .addr   (bus_addr),
    .be     (bus_be),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .slot   (slot),
    .rd_ok  (rd_ok),
    .wr_ok  (wr_ok),
    .reject (reject)
  );

  clkctl_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ok (wr_ok),
    .slot  (slot),
    .wdata (bus_wdata),
    .regs  (regs)
  );

  clkctl_readback u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .rd_ok  (rd_ok),
    .reject (reject),
    .slot   (slot),
    .regs   (regs),
    .rdata  (bus_rdata),
    .err    (bus_err)
  );
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [3:0]    bus_be,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [31:0]   bus_rdata,
  input logic          bus_err
);
  logic bad_acc;
  assign bad_acc = (bus_rd || bus_wr) &&
                   ((bus_be != 4'b1111) || (bus_addr[AW-1:4] != '0));

  p_rd_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_bad_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bad_acc) |=> (bus_rdata == 32'h0));

  p_rosc_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bad_acc && bus_addr[3:2] == 2'd0) |=> bus_rdata[31]);

  p_xosc_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bad_acc && bus_addr[3:2] == 2'd1) |=> bus_rdata[31]);

  p_pll_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bad_acc && bus_addr[3:2] == 2'd2) |=> bus_rdata[31]);

  p_err_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> bus_err);

  p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> !bus_err);
endmodule

bind clkctl_regs clkctl_regs_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err)
);

// File: tb/clkctl_regs_test.sv
module clkctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [3:0]  bus_be;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;

  always #2 clk = ~clk;

  clkctl_regs uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err)
  );

  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  logic [31:0] mdl [4];
  logic [31:0] exp_rd;
  logic        exp_err;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_run++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, want);
    end
  endtask

  // One bus cycle: drive, predict, then compare outputs on the following negedge.
  task automatic step(input string tag, input logic rd, input logic wr,
                      input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    logic bad;
    int   idx;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    bad = (rd || wr) && ((be != 4'hF) || (a[11:4] != 0));
    idx = int'(a[3:2]);
    if (rd) exp_rd = bad ? 32'h0 : mdl[idx];
    exp_err = bad;
    @(negedge clk);
    check({tag, " rdata"}, bus_rdata, exp_rd);
    check({tag, " err"}, {31'h0, bus_err}, {31'h0, exp_err});
    if (wr && !bad) mdl[idx] = d | ((idx != 3) ? 32'h8000_0000 : 32'h0);
    bus_rd = 0; bus_wr = 0;
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_be = 4'hF; bus_wdata = '0;
    mdl[0] = 32'hC000_0000; mdl[1] = 32'hC000_0000;
    mdl[2] = 32'h8006_0000; mdl[3] = 32'h0000_0100;
    exp_rd = 0; exp_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset rdata", bus_rdata, 32'h0);
    check("R1 reset err", {31'h0, bus_err}, 32'h0);
    // R1 reset contents
    for (int i = 0; i < 4; i++) step("R1", 1, 0, 12'(i * 4), 4'hF, 0);
    // R2 ring oscillator ready forced
    step("R2", 0, 1, 12'h000, 4'hF, 32'h0000_0000);
    step("R2", 1, 0, 12'h000, 4'hF, 0);
    step("R2", 0, 1, 12'h000, 4'hF, 32'h4000_00A5);
    step("R2", 1, 0, 12'h000, 4'hF, 0);
    // R3 crystal oscillator ready forced
    step("R3", 0, 1, 12'h004, 4'hF, 32'h1234_5678);
    step("R3", 1, 0, 12'h004, 4'hF, 0);
    // R4 PLL lock forced
    step("R4", 0, 1, 12'h008, 4'hF, 32'h0000_0000);
    step("R4", 1, 0, 12'h008, 4'hF, 0);
    step("R4", 0, 1, 12'h008, 4'hF, 32'h7FFF_FFFF);
    step("R4", 1, 0, 12'h008, 4'hF, 0);
    // R5 divider stored exactly
    step("R5", 0, 1, 12'h00C, 4'hF, 32'h0000_0000);
    step("R5", 1, 0, 12'h00C, 4'hF, 0);
    step("R5", 0, 1, 12'h00C, 4'hF, 32'hFFFF_FFFF);
    step("R5", 1, 0, 12'h00C, 4'hF, 0);
    // R6 rdata holds across idle cycles
    step("R6", 0, 0, 12'h000, 4'hF, 0);
    step("R6", 0, 0, 12'h008, 4'hF, 0);
    // R7 same-cycle read and write returns old value
    step("R7", 1, 1, 12'h00C, 4'hF, 32'h0000_0042);
    step("R7", 1, 0, 12'h00C, 4'hF, 0);
    step("R7", 1, 1, 12'h004, 4'hF, 32'h0000_0001);
    step("R7", 1, 0, 12'h004, 4'hF, 0);
    // R11 low address bits ignored
    step("R11", 0, 1, 12'h007, 4'hF, 32'h0000_0ABC);
    step("R11", 1, 0, 12'h005, 4'hF, 0);
    step("R11", 1, 0, 12'h00E, 4'hF, 0);
    // R8 unmapped reads
    step("R8", 1, 0, 12'h010, 4'hF, 0);
    step("R8", 1, 0, 12'hFFC, 4'hF, 0);
    step("R12", 0, 0, 12'h010, 4'hF, 0);
    // R9 unmapped writes leave every register alone
    step("R9", 0, 1, 12'h800, 4'hF, 32'hDEAD_BEEF);
    step("R9", 0, 1, 12'h01C, 4'hF, 32'h0000_0000);
    for (int i = 0; i < 4; i++) step("R9", 1, 0, 12'(i * 4), 4'hF, 0);
    // R10 narrow accesses rejected
    step("R10", 0, 1, 12'h00C, 4'h3, 32'h1111_1111);
    step("R10", 0, 1, 12'h000, 4'h1, 32'h0000_0000);
    step("R10", 1, 0, 12'h00C, 4'hF, 0);
    step("R10", 1, 0, 12'h000, 4'hF, 0);
    step("R10", 1, 0, 12'h008, 4'hC, 0);
    step("R10", 1, 1, 12'h004, 4'h0, 32'h0);
    step("R12", 0, 0, 12'h000, 4'hF, 0);
    step("R12", 0, 0, 12'h000, 4'h0, 0);
    step("R12", 1, 0, 12'h004, 4'hF, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule